// File: doc/BRIEF.md
# Programmable Oscillator Frequency Planner

This block turns a requested clock frequency into the settings that a crystal-referenced, digitally controlled oscillator needs to produce it. It chooses a high-speed divider and an output divider so that the internal oscillator runs inside its legal window. It then divides the oscillator frequency by the device's own crystal frequency to get a 38-bit multiplier word with 28 fractional bits. Frequencies are unsigned integers in kHz. The crystal frequency carries `XFRAC` extra fractional bits.

A second mode runs the same arithmetic in reverse. It takes the divider codes and multiplier word read from a freshly powered device, together with that device's known default output frequency, and derives the crystal frequency of that particular unit. The planning mode then uses that crystal frequency. Nominal values and values measured on other units are not valid for this step.

Both modes share one serial restoring divider. A run starts with a one-cycle strobe. It ends with a one-cycle done pulse and an error flag. All result outputs are held until the next completed run.

Top module: `fqp_planner`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and hs_code_o, n1_code_o, rfreq_o and xtal_o are zero.
- R2: In planning mode (calib_i=0) the block chooses, among high-speed dividers {4,5,6,7,9,11} and output dividers {1,2,4,6,...,128}, the pair whose oscillator frequency fout×hs×n1 is the lowest value inside [4 850 000, 5 670 000] kHz, bounds included. It reports hs_code_o = hs−4 and n1_code_o = n1−1.
- R3: When two pairs give the same lowest oscillator frequency, the pair with the larger high-speed divider is chosen.
- R4: On a planning success, rfreq_o = floor(fout×hs×n1×2^(28+XFRAC) / xtal_i), and xtal_o echoes xtal_i.
- R5: A request with fout_i below 10 000 kHz or above 1 400 000 kHz ends with err_o high and all result outputs zero. This applies in both modes.
- R6: In planning mode, if no divider pair lands in the window, or if the multiplier does not fit in 38 bits, err_o goes high and all result outputs, the multiplier included, are zero.
- R7: In calibration mode (calib_i=1), xtal_o = floor(fout×hs×n1×2^(28+XFRAC) / cal_rfreq_i). The divider codes and the multiplier word are echoed on hs_code_o, n1_code_o and rfreq_o.
- R8: In calibration mode, any of the following ends with err_o high and all result outputs zero: a high-speed code of 4 or 6, an output-divider code that gives an odd divider above 1, a zero multiplier word, or a crystal result that does not fit in XTAL_W bits.
- R9: A start strobe that arrives while busy_o is high is ignored, and the running computation completes with its original inputs.
- R10: done_o is high for exactly one cycle per accepted start, busy_o is low in that cycle, and the result outputs change only in cycles where done_o is high.
- R11: In planning mode a zero crystal frequency ends with err_o high and all result outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| calib_i | input | 1 | 0 = plan dividers and multiplier, 1 = derive crystal frequency |
| fout_i | input | FREQ_W | Requested or default output frequency, kHz |
| xtal_i | input | XTAL_W | Crystal frequency, kHz with XFRAC fractional bits (planning) |
| cal_hs_i | input | 3 | High-speed divider code read from the device (calibration) |
| cal_n1_i | input | N1_W | Output divider code read from the device (calibration) |
| cal_rfreq_i | input | RF_W | Multiplier word read from the device (calibration) |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last completed run failed |
| hs_code_o | output | 3 | High-speed divider code, hs−4 |
| n1_code_o | output | N1_W | Output divider code, n1−1 |
| rfreq_o | output | RF_W | Multiplier word, 28 fractional bits |
| xtal_o | output | XTAL_W | Crystal frequency used or derived |

## Verification
The bench builds the block with its default parameters: kHz units, eight fractional crystal bits and output dividers up to 128. With these values every divider pair a real request can need is reachable. An arithmetic reference scans all 6×65 pairs for each request. About sixty output frequencies spread over the whole range are planned, along with the range edges, a frequency in an uncovered gap band, and a case with an exact tie. Each successful plan is also fed back through calibration, so that every crystal value derived from a planned word is compared against an independent quotient.

// File: rtl/fqp_pkg.sv
package fqp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SEARCH = 2'd1,
        PH_DIVIDE = 2'd2
    } phase_e;

    localparam int HS_CHOICES = 6;

    // high-speed divider value by scan position, largest first
    function automatic logic [3:0] hs_of_index(input logic [2:0] idx);
        case (idx)
            3'd0:    return 4'd11;
            3'd1:    return 4'd9;
            3'd2:    return 4'd7;
            3'd3:    return 4'd6;
            3'd4:    return 4'd5;
            default: return 4'd4;
        endcase
    endfunction

    function automatic logic [3:0] hs_of_code(input logic [2:0] code);
        return {1'b0, code} + 4'd4;
    endfunction

    function automatic logic hs_code_legal(input logic [2:0] code);
        return (code != 3'd4) && (code != 3'd6);
    endfunction

endpackage

// File: rtl/fqp_pair_search.sv
module fqp_pair_search
    import fqp_pkg::*;
#(
    parameter int FREQ_W = 21,
    parameter int N1_W   = 7,
    parameter int DCO_W  = 33,
    parameter longint unsigned DCO_MIN = 64'd4850000,
    parameter longint unsigned DCO_MAX = 64'd5670000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] fout_i,
    output logic              done_o,
    output logic              found_o,
    output logic [2:0]        hs_code_o,
    output logic [N1_W-1:0]   n1_code_o,
    output logic [DCO_W-1:0]  dco_o
);
    localparam int CNT_W = N1_W + 1;
    localparam logic [CNT_W-1:0] N1_LIMIT = CNT_W'(1 << N1_W);
    localparam logic [DCO_W-1:0] WIN_LO = DCO_W'(DCO_MIN);
    localparam logic [DCO_W-1:0] WIN_HI = DCO_W'(DCO_MAX);
    localparam logic [2:0] LAST_IDX = 3'(HS_CHOICES - 1);

    typedef struct packed {
        logic              run;
        logic              done;
        logic [2:0]        idx;
        logic [CNT_W-1:0]  n1;
        logic [FREQ_W-1:0] fout;
        logic              found;
        logic [DCO_W-1:0]  best_dco;
        logic [2:0]        best_hs;
        logic [CNT_W-1:0]  best_n1;
    } scan_t;

    scan_t s_q, s_d;
    logic [3:0]       hs_now;
    logic [DCO_W-1:0] prod;
    logic             past_end;
    logic             next_hs;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        next_hs  = 1'b0;
        hs_now   = hs_of_index(s_q.idx);
        prod     = DCO_W'(s_q.fout) * DCO_W'(hs_now) * DCO_W'(s_q.n1);
        past_end = (prod > WIN_HI) || (s_q.n1 > N1_LIMIT);

        if (!s_q.run) begin
            if (start_i) begin
                s_d.run   = 1'b1;
                s_d.idx   = 3'd0;
                s_d.n1    = CNT_W'(1);
                s_d.fout  = fout_i;
                s_d.found = 1'b0;
            end
        end else begin
            if (past_end) begin
                next_hs = 1'b1;
            end else if (prod >= WIN_LO) begin
                // first in-window divider for this hs is its lowest
                if (!s_q.found || (prod < s_q.best_dco)) begin
                    s_d.found    = 1'b1;
                    s_d.best_dco = prod;
                    s_d.best_hs  = 3'(hs_now - 4'd4);
                    s_d.best_n1  = s_q.n1;
                end
                next_hs = 1'b1;
            end else begin
                s_d.n1 = (s_q.n1 == CNT_W'(1)) ? CNT_W'(2) : s_q.n1 + CNT_W'(2);
            end

            if (next_hs) begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 3'd1;
                    s_d.n1  = CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o    = s_q.done;
    assign found_o   = s_q.found;
    assign hs_code_o = s_q.best_hs;
    assign n1_code_o = N1_W'(s_q.best_n1 - CNT_W'(1));
    assign dco_o     = s_q.best_dco;

endmodule

// File: rtl/fqp_divider.sv
module fqp_divider #(
    parameter int NUM_W = 69,
    parameter int DEN_W = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
    } div_t;

    div_t r_q, r_d;
    logic [DEN_W:0] trial;
    logic           fits;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        trial    = {r_q.rem, r_q.quo[NUM_W-1]};
        fits     = trial >= {1'b0, r_q.den};

        if (!r_q.run) begin
            if (start_i) begin
                r_d.run = 1'b1;
                r_d.cnt = CNT_W'(NUM_W);
                r_d.rem = '0;
                r_d.quo = num_i;
                r_d.den = den_i;
            end
        end else begin
            r_d.rem = fits ? DEN_W'(trial - {1'b0, r_q.den}) : DEN_W'(trial);
            r_d.quo = {r_q.quo[NUM_W-2:0], fits};
            r_d.cnt = r_q.cnt - CNT_W'(1);
            if (r_q.cnt == CNT_W'(1)) begin
                r_d.run  = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign quot_o = r_q.quo;

endmodule

// File: rtl/fqp_planner.sv
module fqp_planner
    import fqp_pkg::*;
#(
    parameter int FREQ_W  = 21,
    parameter int XFRAC   = 8,
    parameter int XTAL_W  = 28,
    parameter int N1_W    = 7,
    parameter int RF_W    = 38,
    parameter int RF_FRAC = 28,
    parameter longint unsigned FOUT_MIN = 64'd10000,
    parameter longint unsigned FOUT_MAX = 64'd1400000,
    parameter longint unsigned DCO_MIN  = 64'd4850000,
    parameter longint unsigned DCO_MAX  = 64'd5670000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              calib_i,
    input  logic [FREQ_W-1:0] fout_i,
    input  logic [XTAL_W-1:0] xtal_i,
    input  logic [2:0]        cal_hs_i,
    input  logic [N1_W-1:0]   cal_n1_i,
    input  logic [RF_W-1:0]   cal_rfreq_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [2:0]        hs_code_o,
    output logic [N1_W-1:0]   n1_code_o,
    output logic [RF_W-1:0]   rfreq_o,
    output logic [XTAL_W-1:0] xtal_o
);
    localparam int DCO_W = FREQ_W + 4 + N1_W + 1;
    localparam int SHIFT = RF_FRAC + XFRAC;
    localparam int NUM_W = DCO_W + SHIFT;
    localparam int DEN_W = (RF_W > XTAL_W) ? RF_W : XTAL_W;
    localparam logic [FREQ_W-1:0] FO_LO = FREQ_W'(FOUT_MIN);
    localparam logic [FREQ_W-1:0] FO_HI = FREQ_W'(FOUT_MAX);

    typedef struct packed {
        phase_e            phase;
        logic              busy;
        logic              done;
        logic              err;
        logic              calib;
        logic [XTAL_W-1:0] xtal;
        logic [2:0]        hs;
        logic [N1_W-1:0]   n1;
        logic [RF_W-1:0]   rf;
        logic [2:0]        hs_r;
        logic [N1_W-1:0]   n1_r;
        logic [RF_W-1:0]   rf_r;
        logic [XTAL_W-1:0] xt_r;
    } ctl_t;

    ctl_t c_q, c_d;

    logic              srch_start, srch_done, srch_found;
    logic [2:0]        srch_hs;
    logic [N1_W-1:0]   srch_n1;
    logic [DCO_W-1:0]  srch_dco;
    logic              div_start, div_done;
    logic [NUM_W-1:0]  div_num, div_quot;
    logic [DEN_W-1:0]  div_den;
    logic [DCO_W-1:0]  cal_dco, dco_sel;
    logic              fout_ok, cal_ok, fail, succeed;

    fqp_pair_search #(
        .FREQ_W (FREQ_W),
        .N1_W   (N1_W),
        .DCO_W  (DCO_W),
        .DCO_MIN(DCO_MIN),
        .DCO_MAX(DCO_MAX)
    ) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (srch_start),
        .fout_i   (fout_i),
        .done_o   (srch_done),
        .found_o  (srch_found),
        .hs_code_o(srch_hs),
        .n1_code_o(srch_n1),
        .dco_o    (srch_dco)
    );

    fqp_divider #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W)
    ) u_divider (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_start),
        .num_i  (div_num),
        .den_i  (div_den),
        .done_o (div_done),
        .quot_o (div_quot)
    );

    // divider operands: calibration is launched from idle, planning from search
    assign cal_dco = DCO_W'(fout_i) * DCO_W'(hs_of_code(cal_hs_i))
                   * DCO_W'({1'b0, cal_n1_i} + (N1_W + 1)'(1));
    assign dco_sel = (c_q.phase == PH_IDLE) ? cal_dco : srch_dco;
    assign div_num = NUM_W'(dco_sel) << SHIFT;
    assign div_den = (c_q.phase == PH_IDLE) ? DEN_W'(cal_rfreq_i) : DEN_W'(c_q.xtal);

    assign fout_ok = (fout_i >= FO_LO) && (fout_i <= FO_HI);
    assign cal_ok  = fout_ok && hs_code_legal(cal_hs_i)
                   && ((cal_n1_i == '0) || cal_n1_i[0]) && (cal_rfreq_i != '0);

    always_comb begin
        c_d        = c_q;
        c_d.done   = 1'b0;
        srch_start = 1'b0;
        div_start  = 1'b0;
        fail       = 1'b0;
        succeed    = 1'b0;

        case (c_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    c_d.calib = calib_i;
                    c_d.xtal  = xtal_i;
                    c_d.hs    = cal_hs_i;
                    c_d.n1    = cal_n1_i;
                    c_d.rf    = cal_rfreq_i;
                    if (calib_i) begin
                        if (!cal_ok) begin
                            fail = 1'b1;
                        end else begin
                            div_start = 1'b1;
                            c_d.phase = PH_DIVIDE;
                            c_d.busy  = 1'b1;
                        end
                    end else begin
                        if (!fout_ok || (xtal_i == '0)) begin
                            fail = 1'b1;
                        end else begin
                            srch_start = 1'b1;
                            c_d.phase  = PH_SEARCH;
                            c_d.busy   = 1'b1;
                        end
                    end
                end
            end
            PH_SEARCH: begin
                if (srch_done) begin
                    if (!srch_found) begin
                        fail = 1'b1;
                    end else begin
                        div_start = 1'b1;
                        c_d.hs    = srch_hs;
                        c_d.n1    = srch_n1;
                        c_d.phase = PH_DIVIDE;
                    end
                end
            end
            PH_DIVIDE: begin
                if (div_done) begin
                    if (c_q.calib) begin
                        if (div_quot[NUM_W-1:XTAL_W] != '0) begin
                            fail = 1'b1;
                        end else begin
                            succeed  = 1'b1;
                            c_d.rf_r = c_q.rf;
                            c_d.xt_r = div_quot[XTAL_W-1:0];
                        end
                    end else begin
                        if (div_quot[NUM_W-1:RF_W] != '0) begin
                            fail = 1'b1;
                        end else begin
                            succeed  = 1'b1;
                            c_d.rf_r = div_quot[RF_W-1:0];
                            c_d.xt_r = c_q.xtal;
                        end
                    end
                    c_d.hs_r = c_q.hs;
                    c_d.n1_r = c_q.n1;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase

        if (fail || succeed) begin
            c_d.phase = PH_IDLE;
            c_d.busy  = 1'b0;
            c_d.done  = 1'b1;
            c_d.err   = fail;
        end
        if (fail) begin
            c_d.hs_r = '0;
            c_d.n1_r = '0;
            c_d.rf_r = '0;
            c_d.xt_r = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_o    = c_q.busy;
    assign done_o    = c_q.done;
    assign err_o     = c_q.err;
    assign hs_code_o = c_q.hs_r;
    assign n1_code_o = c_q.n1_r;
    assign rfreq_o   = c_q.rf_r;
    assign xtal_o    = c_q.xt_r;

endmodule

// File: rtl/fqp_checker.sv
module fqp_checker #(
    parameter int N1_W   = 7,
    parameter int RF_W   = 38,
    parameter int XTAL_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [2:0]        hs_code_o,
    input logic [N1_W-1:0]   n1_code_o,
    input logic [RF_W-1:0]   rfreq_o,
    input logic [XTAL_W-1:0] xtal_o
);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(rfreq_o) && $stable(xtal_o)
                     && $stable(hs_code_o) && $stable(n1_code_o)));

    a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R5, R6, R8, R11: a failed run leaves every result cleared
    a_r6_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (rfreq_o == '0 && xtal_o == '0
                               && hs_code_o == 3'd0 && n1_code_o == '0));

    a_r2_codes_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (hs_code_o != 3'd4 && hs_code_o != 3'd6
                                && (n1_code_o == '0 || n1_code_o[0])
                                && rfreq_o != '0));

endmodule

bind fqp_planner fqp_checker #(
    .N1_W  (N1_W),
    .RF_W  (RF_W),
    .XTAL_W(XTAL_W)
) u_fqp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .hs_code_o(hs_code_o),
    .n1_code_o(n1_code_o),
    .rfreq_o  (rfreq_o),
    .xtal_o   (xtal_o)
);

// File: tb/tb_fqp_planner.sv
module tb_fqp_planner;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam logic [27:0] XTAL_NOM = 28'd29257050;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        calib_i = 1'b0;
    logic [20:0] fout_i = '0;
    logic [27:0] xtal_i = '0;
    logic [2:0]  cal_hs_i = '0;
    logic [6:0]  cal_n1_i = '0;
    logic [37:0] cal_rfreq_i = '0;
    logic        busy_o, done_o, err_o;
    logic [2:0]  hs_code_o;
    logic [6:0]  n1_code_o;
    logic [37:0] rfreq_o;
    logic [27:0] xtal_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    fqp_planner dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .calib_i(calib_i),
        .fout_i(fout_i), .xtal_i(xtal_i), .cal_hs_i(cal_hs_i),
        .cal_n1_i(cal_n1_i), .cal_rfreq_i(cal_rfreq_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .hs_code_o(hs_code_o), .n1_code_o(n1_code_o),
        .rfreq_o(rfreq_o), .xtal_o(xtal_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // arithmetic reference for planning
    task automatic plan_ref(input int unsigned fo, input logic [27:0] xt, output bit e,
                            output logic [2:0] hc, output logic [6:0] nc,
                            output logic [37:0] rf);
        int unsigned hsv[6] = '{11, 9, 7, 6, 5, 4};
        longint unsigned best = 0;
        int unsigned bh = 0, bn = 0;
        bit found = 0;
        logic [79:0] q;
        e = 0; hc = '0; nc = '0; rf = '0;
        if (fo < 10000 || fo > 1400000 || xt == 0) begin e = 1; return; end
        for (int hi = 0; hi < 6; hi++) begin
            for (int n = 1; n <= 128; n = (n == 1) ? 2 : n + 2) begin
                longint unsigned d = longint'(fo) * hsv[hi] * n;
                if (d >= 4850000 && d <= 5670000 && (!found || d < best)) begin
                    found = 1; best = d; bh = hsv[hi]; bn = n;
                end
            end
        end
        if (!found) begin e = 1; return; end
        q = (80'(best) << 36) / 80'(xt);
        if (q >= (80'd1 << 38)) begin e = 1; return; end
        rf = q[37:0];
        hc = 3'(bh - 4);
        nc = 7'(bn - 1);
    endtask

    task automatic cal_ref(input int unsigned fo, input logic [2:0] hc, input logic [6:0] nc,
                           input logic [37:0] rf, output bit e, output logic [27:0] xt);
        logic [79:0] q;
        e = 0; xt = '0;
        if (fo < 10000 || fo > 1400000 || hc == 3'd4 || hc == 3'd6
            || (nc != 0 && !nc[0]) || rf == 0) begin e = 1; return; end
        q = ((80'(fo) * 80'(hc + 4) * 80'(nc + 1)) << 36) / 80'(rf);
        if (q >= (80'd1 << 28)) begin e = 1; return; end
        xt = q[27:0];
    endtask

    task automatic launch(input bit cal, input int unsigned fo, input logic [27:0] xt,
                          input logic [2:0] hc, input logic [6:0] nc, input logic [37:0] rf);
        int n = 0;
        @(negedge clk);
        calib_i = cal; fout_i = 21'(fo); xtal_i = xt;
        cal_hs_i = hc; cal_n1_i = nc; cal_rfreq_i = rf;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o, "R10 done reached", 80'(done_o), 80'd1);
    endtask

    task automatic check_result(input string req, input bit e, input logic [2:0] hc,
                                input logic [6:0] nc, input logic [37:0] rf,
                                input logic [27:0] xt);
        chk(err_o == e, req, 80'(err_o), 80'(e));
        chk(hs_code_o == hc && n1_code_o == nc, req, {hs_code_o, n1_code_o}, {hc, nc});
        chk(rfreq_o == rf, req, 80'(rfreq_o), 80'(rf));
        chk(xtal_o == xt, req, 80'(xtal_o), 80'(xt));
        chk(!busy_o, "R10 busy low at done", 80'(busy_o), 80'd0);
    endtask

    task automatic plan_and_check(input int unsigned fo, input logic [27:0] xt,
                                  input string req, input bit also_cal);
        bit e, ce;
        logic [2:0] hc;
        logic [6:0] nc;
        logic [37:0] rf;
        logic [27:0] cx;
        plan_ref(fo, xt, e, hc, nc, rf);
        launch(1'b0, fo, xt, 3'd0, 7'd0, 38'd0);
        check_result(req, e, hc, nc, rf, e ? 28'd0 : xt);
        @(negedge clk);
        chk(!done_o, "R10 done one cycle", 80'(done_o), 80'd0);
        if (also_cal && !e) begin
            cal_ref(fo, hc, nc, rf, ce, cx);
            launch(1'b1, fo, 28'd0, hc, nc, rf);
            check_result("R7 calibration from planned word", ce, ce ? 3'd0 : hc,
                         ce ? 7'd0 : nc, ce ? 38'd0 : rf, cx);
        end
    endtask

    initial begin
        // R1 reset state
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk(!busy_o && !done_o && !err_o, "R1 flags after reset",
            80'({busy_o, done_o, err_o}), 80'd0);
        chk(hs_code_o == 0 && n1_code_o == 0 && rfreq_o == 0 && xtal_o == 0,
            "R1 results after reset", 80'(rfreq_o), 80'd0);
        rst_n = 1'b1;

        // R2 R4 sweep across the output range, each success fed back through R7
        for (int k = 0; k < 58; k++)
            plan_and_check(10000 + k * 24000, XTAL_NOM, "R2 R4 sweep", (k % 3) == 0);

        // R5 range edges
        plan_and_check(10000, XTAL_NOM, "R5 lower edge accepted", 1'b1);
        plan_and_check(9999, XTAL_NOM, "R5 below range", 1'b0);
        plan_and_check(1400000, XTAL_NOM, "R5 upper edge accepted", 1'b1);
        plan_and_check(1400001, XTAL_NOM, "R5 above range", 1'b0);
        plan_and_check(945000, XTAL_NOM, "R2 top of continuous band", 1'b1);

        // R3 tie: 210000 kHz x 24 with (6,4) and (4,6); expect hs code 2, n1 code 3
        plan_and_check(210000, XTAL_NOM, "R3 tie resolution", 1'b0);
        chk(hs_code_o == 3'd2 && n1_code_o == 7'd3, "R3 larger hs wins",
            {hs_code_o, n1_code_o}, {3'd2, 7'd3});

        // R6 gap band with no valid pair, and multiplier overflow
        plan_and_check(1200000, XTAL_NOM, "R6 no divider pair", 1'b0);
        plan_and_check(100000, 28'd1, "R6 multiplier overflow", 1'b0);

        // R11 zero crystal
        plan_and_check(100000, 28'd0, "R11 zero crystal", 1'b0);

        // R8 calibration input faults
        launch(1'b1, 100000, 28'd0, 3'd4, 7'd49, 38'h0B_6000_0000);
        check_result("R8 hs code 4", 1'b1, 3'd0, 7'd0, 38'd0, 28'd0);
        launch(1'b1, 100000, 28'd0, 3'd6, 7'd49, 38'h0B_6000_0000);
        check_result("R8 hs code 6", 1'b1, 3'd0, 7'd0, 38'd0, 28'd0);
        launch(1'b1, 100000, 28'd0, 3'd1, 7'd2, 38'h0B_6000_0000);
        check_result("R8 odd n1", 1'b1, 3'd0, 7'd0, 38'd0, 28'd0);
        launch(1'b1, 100000, 28'd0, 3'd1, 7'd9, 38'd0);
        check_result("R8 zero word", 1'b1, 3'd0, 7'd0, 38'd0, 28'd0);
        launch(1'b1, 100000, 28'd0, 3'd1, 7'd9, 38'd1);
        check_result("R8 crystal overflow", 1'b1, 3'd0, 7'd0, 38'd0, 28'd0);
        launch(1'b1, 9000, 28'd0, 3'd1, 7'd9, 38'h0B_6000_0000);
        check_result("R5 calibration below range", 1'b1, 3'd0, 7'd0, 38'd0, 28'd0);

        // R9 start during busy is ignored
        begin
            bit e;
            logic [2:0] hc;
            logic [6:0] nc;
            logic [37:0] rf;
            int n = 0;
            plan_ref(156250, XTAL_NOM, e, hc, nc, rf);
            @(negedge clk);
            calib_i = 1'b0; fout_i = 21'd156250; xtal_i = XTAL_NOM; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
            chk(busy_o, "R9 busy while running", 80'(busy_o), 80'd1);
            fout_i = 21'd622080; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (!done_o && n < 5000) begin
                @(negedge clk);
                n++;
            end
            check_result("R9 second start ignored", e, hc, nc, rf, XTAL_NOM);
            @(negedge clk);
            chk(!busy_o && !done_o, "R9 no second run", 80'({busy_o, done_o}), 80'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule